// File: doc/BRIEF.md
# Low-Power Mode Policy Controller

This block decides how a small microcontroller is clocked and powered in each of its operating modes. It keeps the current mode and drives enables for the fast internal oscillator, the high-frequency crystal, the CPU clock, the main bus clock and the low-power bus clock. It also drives the frequency selects for those clocks, the timer clock enable and the regulator drive level.

Software writes the mode it wants on `req_mode_i`. The request takes effect only on a wait-for-interrupt strobe issued while the core runs. Each low-power depth leaves only on its own class of wake event, and it returns to the run level held before entry. The deepest mode, shutdown, returns to run level 0 and raises a flag reporting that configuration was lost.

The clock outputs are registered and follow the mode one cycle later. A clock sourced from the fast oscillator is enabled only in a cycle where the oscillator reports ready.

Top module: `lpm_policy_ctrl`

## Requirements
- R1: `mode_o` encodes RUN0..RUN2 as 0..2, SLEEP0..SLEEP2 as 3..5, STOP0..STOP2 as 6..8, STANDBY0/1 as 9/10 and SHUTDOWN as 11. `req_mode_i` values 0..2 select that run level, 3 selects sleep at the current level, 4..6 select STOP0..2, 7/8 select STANDBY0/1 and 9 selects shutdown. A request is taken only when `wfi_i` is high in a run mode, and `mode_o` updates on that clock edge.
- R2: The CPU clock is enabled only in run modes. The main bus clock is enabled in run and sleep and disabled in stop, standby and shutdown. `mclk_fast_o` is 1 (32 MHz) at level 0 and 0 (32 kHz) at levels 1 and 2.
- R3: `sysosc_en_o` is 1 in run/sleep levels 0 and 1 and in STOP1. It is 0 in run/sleep level 2, STOP2, both standby modes and shutdown.
- R4: `ulpclk_sel_o` encodes 0 = 32 kHz, 1 = 4 MHz and 2 = 32 MHz. It is 2 at run/sleep level 0, 0 at levels 1 and 2, 1 in STOP1 and 0 in STOP2. In STOP0 it is 1 when entered from RUN0 and 0 when entered from RUN1 or RUN2. The oscillator stays on in STOP0 unless the mode was entered from RUN2. The low-power bus clock is off in standby and shutdown.
- R5: `hfxt_en_o` follows `hfxt_req_i` only in RUN0 and SLEEP0 and is 0 in every other mode.
- R6: Sleep modes leave on `wake_irq_i` or `wake_aon_i`. Stop and standby modes leave only on `wake_aon_i`.
- R7: Shutdown leaves only on `wake_pin_i`. It then enters RUN0 with run level 0 and sets `retention_lost_o`, which clears on the next accepted `wfi_i`.
- R8: `reg_drive_o` is 3 (full) in run and sleep, 2 (reduced) in stop, 1 (low) in standby and 0 (off) in shutdown.
- R9: `tim_clk_en_o` is 1 in run, sleep, stop and STANDBY1. It is 0 in STANDBY0 and shutdown.
- R10: A wake from sleep, stop or standby enters the run level held before entry, and `run_level_o` reports the current run level.
- R11: The CPU and main bus clock enables at 32 MHz, and the low-power bus clock enable at a rate other than 32 kHz, are set only if `osc_rdy_i` was high at the edge that loads them.
- R12: Every clock, select and drive output is registered from the mode held before the edge. Request codes 10..15 leave the mode unchanged. In reset the outputs read `sysosc_en_o`=1, `reg_drive_o`=3 and all other outputs 0, with `mode_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_mode_i | input | 4 | Requested mode code |
| wfi_i | input | 1 | Wait-for-interrupt strobe |
| wake_irq_i | input | 1 | Any interrupt pending |
| wake_aon_i | input | 1 | Always-on domain interrupt |
| wake_pin_i | input | 1 | IO, external reset or debug wake |
| hfxt_req_i | input | 1 | Software wants the crystal on |
| osc_rdy_i | input | 1 | Fast oscillator stable |
| sysosc_en_o | output | 1 | Fast oscillator enable |
| hfxt_en_o | output | 1 | Crystal enable |
| cpuclk_en_o | output | 1 | CPU clock enable |
| mclk_en_o | output | 1 | Main bus clock enable |
| mclk_fast_o | output | 1 | Main bus rate, 1 = 32 MHz |
| ulpclk_en_o | output | 1 | Low-power bus clock enable |
| ulpclk_sel_o | output | 2 | Low-power bus rate select |
| tim_clk_en_o | output | 1 | Timer and RTC clock enable |
| reg_drive_o | output | 2 | Regulator drive level |
| retention_lost_o | output | 1 | Configuration lost after shutdown |
| mode_o | output | 4 | Current mode |
| run_level_o | output | 2 | Current run level |

## Verification
The assertions rely on the inputs being sampled clean at each rising edge. They also rely on a change of mode always being traceable to a strobe or a wake input from the cycle before. The bench changes inputs only at the falling edge. It mixes random strobes, request codes including the unused ones, wake pulses and dropped oscillator-ready cycles with directed entries into STOP0 from every run level and into shutdown. A bench reference model predicts every output each cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int MODE_W = 4;
  localparam int LVL_W  = 2;
  localparam int SEL_W  = 2;
  localparam int DRV_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    M_RUN0 = 4'd0, M_RUN1 = 4'd1, M_RUN2 = 4'd2,
    M_SLP0 = 4'd3, M_SLP1 = 4'd4, M_SLP2 = 4'd5,
    M_STP0 = 4'd6, M_STP1 = 4'd7, M_STP2 = 4'd8,
    M_SBY0 = 4'd9, M_SBY1 = 4'd10, M_SHDN = 4'd11
  } mode_e;

  localparam logic [MODE_W-1:0] REQ_SLEEP = 4'd3;
  localparam logic [MODE_W-1:0] REQ_STOP0 = 4'd4;
  localparam logic [MODE_W-1:0] REQ_SHDN  = 4'd9;
  localparam logic [MODE_W-1:0] REQ_OFS   = 4'd2;  // request code to mode code for stop/standby/shutdown

  localparam logic [SEL_W-1:0] ULP_32K = 2'd0;
  localparam logic [SEL_W-1:0] ULP_4M  = 2'd1;
  localparam logic [SEL_W-1:0] ULP_32M = 2'd2;

  localparam logic [DRV_W-1:0] DRV_OFF  = 2'd0;
  localparam logic [DRV_W-1:0] DRV_LOW  = 2'd1;
  localparam logic [DRV_W-1:0] DRV_RED  = 2'd2;
  localparam logic [DRV_W-1:0] DRV_FULL = 2'd3;

  typedef struct packed {
    logic             sysosc;
    logic             hfxt_ok;
    logic             cpu;
    logic             mclk;
    logic             mclk_fast;
    logic             ulp;
    logic [SEL_W-1:0] ulp_sel;
    logic             tim;
    logic [DRV_W-1:0] drive;
  } cfg_t;
endpackage

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] req_i,
  input  logic              wfi_i,
  input  logic              wake_irq_i,
  input  logic              wake_aon_i,
  input  logic              wake_pin_i,
  output mode_e             mode_o,
  output logic [LVL_W-1:0]  lvl_o,
  output logic              ret_lost_o
);
  mode_e             mode_q, mode_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic              ret_q, ret_d;

  always_comb begin
    mode_d = mode_q;
    lvl_d  = lvl_q;
    ret_d  = ret_q;
    case (mode_q)
      M_RUN0, M_RUN1, M_RUN2: begin
        if (wfi_i) begin
          ret_d = 1'b0;
          if (req_i < REQ_SLEEP) begin
            lvl_d  = req_i[LVL_W-1:0];
            mode_d = mode_e'(req_i);
          end else if (req_i == REQ_SLEEP) begin
            mode_d = mode_e'(M_SLP0 + MODE_W'(lvl_q));
          end else if (req_i >= REQ_STOP0 && req_i <= REQ_SHDN) begin
            mode_d = mode_e'(req_i + REQ_OFS);
          end
        end
      end
      M_SLP0, M_SLP1, M_SLP2: begin
        if (wake_irq_i || wake_aon_i) mode_d = mode_e'(MODE_W'(lvl_q));
      end
      M_STP0, M_STP1, M_STP2, M_SBY0, M_SBY1: begin
        if (wake_aon_i) mode_d = mode_e'(MODE_W'(lvl_q));
      end
      M_SHDN: begin
        if (wake_pin_i) begin
          mode_d = M_RUN0;
          lvl_d  = '0;
          ret_d  = 1'b1;
        end
      end
      default: begin
        mode_d = M_RUN0;
        lvl_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_RUN0;
      lvl_q  <= '0;
      ret_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      lvl_q  <= lvl_d;
      ret_q  <= ret_d;
    end
  end

  assign mode_o     = mode_q;
  assign lvl_o      = lvl_q;
  assign ret_lost_o = ret_q;
endmodule

// File: rtl/lpm_policy_map.sv
module lpm_policy_map
  import lpm_pkg::*;
(
  input  mode_e            mode_i,
  input  logic [LVL_W-1:0] lvl_i,
  output cfg_t             cfg_o
);
  logic lvl0, lvl2;
  assign lvl0 = (lvl_i == '0);
  assign lvl2 = (lvl_i == LVL_W'(2));

  always_comb begin
    cfg_o = '0;
    case (mode_i)
      M_RUN0, M_RUN1, M_RUN2, M_SLP0, M_SLP1, M_SLP2: begin
        cfg_o.cpu       = (mode_i <= M_RUN2);
        cfg_o.mclk      = 1'b1;
        cfg_o.mclk_fast = lvl0;
        cfg_o.sysosc    = !lvl2;
        cfg_o.hfxt_ok   = lvl0;
        cfg_o.ulp       = 1'b1;
        cfg_o.ulp_sel   = lvl0 ? ULP_32M : ULP_32K;
        cfg_o.tim       = 1'b1;
        cfg_o.drive     = DRV_FULL;
      end
      M_STP0: begin
        // entry run level picks the stop-0 flavour
        cfg_o.sysosc  = !lvl2;
        cfg_o.ulp     = 1'b1;
        cfg_o.ulp_sel = lvl0 ? ULP_4M : ULP_32K;
        cfg_o.tim     = 1'b1;
        cfg_o.drive   = DRV_RED;
      end
      M_STP1: begin
        cfg_o.sysosc  = 1'b1;
        cfg_o.ulp     = 1'b1;
        cfg_o.ulp_sel = ULP_4M;
        cfg_o.tim     = 1'b1;
        cfg_o.drive   = DRV_RED;
      end
      M_STP2: begin
        cfg_o.ulp     = 1'b1;
        cfg_o.ulp_sel = ULP_32K;
        cfg_o.tim     = 1'b1;
        cfg_o.drive   = DRV_RED;
      end
      M_SBY0, M_SBY1: begin
        cfg_o.tim   = (mode_i == M_SBY1);
        cfg_o.drive = DRV_LOW;
      end
      default: cfg_o = '0;
    endcase
  end
endmodule

// File: rtl/lpm_clk_gate.sv
module lpm_clk_gate
  import lpm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cfg_t cfg_i,
  input  logic hfxt_req_i,
  input  logic osc_rdy_i,
  output cfg_t cfg_o
);
  cfg_t d, q;

  always_comb begin
    d           = cfg_i;
    d.cpu       = cfg_i.cpu  && (!cfg_i.mclk_fast || osc_rdy_i);
    d.mclk      = cfg_i.mclk && (!cfg_i.mclk_fast || osc_rdy_i);
    d.ulp       = cfg_i.ulp  && ((cfg_i.ulp_sel == ULP_32K) || osc_rdy_i);
    d.hfxt_ok   = cfg_i.hfxt_ok && hfxt_req_i;
  end

  // enables change only at the clock edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q        <= '0;
      q.sysosc <= 1'b1;
      q.drive  <= DRV_FULL;
    end else begin
      q <= d;
    end
  end

  assign cfg_o = q;
endmodule

// File: rtl/lpm_policy_ctrl.sv
module lpm_policy_ctrl
  import lpm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] req_mode_i,
  input  logic              wfi_i,
  input  logic              wake_irq_i,
  input  logic              wake_aon_i,
  input  logic              wake_pin_i,
  input  logic              hfxt_req_i,
  input  logic              osc_rdy_i,
  output logic              sysosc_en_o,
  output logic              hfxt_en_o,
  output logic              cpuclk_en_o,
  output logic              mclk_en_o,
  output logic              mclk_fast_o,
  output logic              ulpclk_en_o,
  output logic [SEL_W-1:0]  ulpclk_sel_o,
  output logic              tim_clk_en_o,
  output logic [DRV_W-1:0]  reg_drive_o,
  output logic              retention_lost_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [LVL_W-1:0]  run_level_o
);
  mode_e            mode;
  logic [LVL_W-1:0] lvl;
  cfg_t             cfg_raw, cfg_q;

  lpm_mode_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_mode_i),
    .wfi_i      (wfi_i),
    .wake_irq_i (wake_irq_i),
    .wake_aon_i (wake_aon_i),
    .wake_pin_i (wake_pin_i),
    .mode_o     (mode),
    .lvl_o      (lvl),
    .ret_lost_o (retention_lost_o)
  );

  lpm_policy_map u_map (
    .mode_i (mode),
    .lvl_i  (lvl),
    .cfg_o  (cfg_raw)
  );

  lpm_clk_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg_raw),
    .hfxt_req_i (hfxt_req_i),
    .osc_rdy_i  (osc_rdy_i),
    .cfg_o      (cfg_q)
  );

  assign sysosc_en_o  = cfg_q.sysosc;
  assign hfxt_en_o    = cfg_q.hfxt_ok;
  assign cpuclk_en_o  = cfg_q.cpu;
  assign mclk_en_o    = cfg_q.mclk;
  assign mclk_fast_o  = cfg_q.mclk_fast;
  assign ulpclk_en_o  = cfg_q.ulp;
  assign ulpclk_sel_o = cfg_q.ulp_sel;
  assign tim_clk_en_o = cfg_q.tim;
  assign reg_drive_o  = cfg_q.drive;
  assign mode_o       = mode;
  assign run_level_o  = lvl;
endmodule

// File: rtl/lpm_policy_chk.sv
module lpm_policy_chk
  import lpm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wfi_i,
  input logic              wake_irq_i,
  input logic              wake_aon_i,
  input logic              wake_pin_i,
  input logic              osc_rdy_i,
  input logic              hfxt_en_o,
  input logic              cpuclk_en_o,
  input logic              mclk_fast_o,
  input logic [DRV_W-1:0]  reg_drive_o,
  input logic [MODE_W-1:0] mode_o
);
  p_mode_change_cause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != $past(mode_o)) |-> $past(wfi_i || wake_irq_i || wake_aon_i || wake_pin_i));

  p_cpu_run_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpuclk_en_o |-> ($past(mode_o) <= 4'd2));

  p_hfxt_lvl0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hfxt_en_o |-> ($past(mode_o) == 4'd0 || $past(mode_o) == 4'd3));

  p_shdn_pin_wake_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == 4'd11 && mode_o != 4'd11) |-> $past(wake_pin_i));

  p_drive_off_shdn_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_drive_o == DRV_OFF) |-> ($past(mode_o) == 4'd11));

  p_fast_needs_rdy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpuclk_en_o && mclk_fast_o) |-> $past(osc_rdy_i));
endmodule

bind lpm_policy_ctrl lpm_policy_chk u_chk (.*);

// File: tb/tb_lpm_policy_ctrl.sv
module tb_lpm_policy_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [3:0] req_mode_i;
  logic       wfi_i, wake_irq_i, wake_aon_i, wake_pin_i, hfxt_req_i, osc_rdy_i;
  logic       sysosc_en_o, hfxt_en_o, cpuclk_en_o, mclk_en_o, mclk_fast_o, ulpclk_en_o;
  logic [1:0] ulpclk_sel_o;
  logic       tim_clk_en_o;
  logic [1:0] reg_drive_o;
  logic       retention_lost_o;
  logic [3:0] mode_o;
  logic [1:0] run_level_o;

  int checks = 0;
  int errors = 0;

  int m_mode, m_lvl, m_ret;
  logic e_sys, e_hx, e_cpu, e_mc, e_fast, e_ulp, e_tim;
  logic [1:0] e_sel, e_drv;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lpm_policy_ctrl dut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1 mode", 8'(mode_o), 8'(m_mode));
    chk("R10 run_level", 8'(run_level_o), 8'(m_lvl));
    chk("R7 retention_lost", 8'(retention_lost_o), 8'(m_ret));
    chk("R3 sysosc", 8'(sysosc_en_o), 8'(e_sys));
    chk("R5 hfxt", 8'(hfxt_en_o), 8'(e_hx));
    chk("R2 cpuclk", 8'(cpuclk_en_o), 8'(e_cpu));
    chk("R2 mclk", 8'(mclk_en_o), 8'(e_mc));
    chk("R2 mclk_fast", 8'(mclk_fast_o), 8'(e_fast));
    chk("R4 ulp_en", 8'(ulpclk_en_o), 8'(e_ulp));
    chk("R4 ulp_sel", 8'(ulpclk_sel_o), 8'(e_sel));
    chk("R9 tim", 8'(tim_clk_en_o), 8'(e_tim));
    chk("R8 drive", 8'(reg_drive_o), 8'(e_drv));
  endtask

  // reference model: outputs from mode before edge (R12), then next mode
  task automatic model_edge();
    logic sys, hx, cpu, mc, fast, ulp, tim;
    logic [1:0] sel, drv;
    int lv;
    sys = 0; hx = 0; cpu = 0; mc = 0; fast = 0; ulp = 0; tim = 0; sel = 0; drv = 0;
    if (m_mode <= 5) begin
      lv = m_mode % 3;
      cpu = (m_mode <= 2); mc = 1; fast = (lv == 0); sys = (lv != 2);
      hx = (lv == 0); ulp = 1; sel = (lv == 0) ? 2'd2 : 2'd0; tim = 1; drv = 3;
    end else if (m_mode == 6) begin
      sys = (m_lvl != 2); ulp = 1; sel = (m_lvl == 0) ? 2'd1 : 2'd0; tim = 1; drv = 2;
    end else if (m_mode == 7) begin
      sys = 1; ulp = 1; sel = 1; tim = 1; drv = 2;
    end else if (m_mode == 8) begin
      ulp = 1; sel = 0; tim = 1; drv = 2;
    end else if (m_mode == 9 || m_mode == 10) begin
      drv = 1; tim = (m_mode == 10);
    end
    e_sys  = sys;
    e_hx   = hx && hfxt_req_i;
    e_cpu  = cpu && (!fast || osc_rdy_i);
    e_mc   = mc && (!fast || osc_rdy_i);
    e_fast = fast;
    e_ulp  = ulp && (sel == 0 || osc_rdy_i);
    e_sel  = sel;
    e_tim  = tim;
    e_drv  = drv;
    if (m_mode <= 2) begin
      if (wfi_i) begin
        m_ret = 0;
        if (req_mode_i <= 2) begin m_mode = int'(req_mode_i); m_lvl = int'(req_mode_i); end
        else if (req_mode_i == 3) m_mode = 3 + m_lvl;
        else if (req_mode_i <= 9) m_mode = int'(req_mode_i) + 2;
      end
    end else if (m_mode <= 5) begin
      if (wake_irq_i || wake_aon_i) m_mode = m_lvl;
    end else if (m_mode <= 10) begin
      if (wake_aon_i) m_mode = m_lvl;
    end else begin
      if (wake_pin_i) begin m_mode = 0; m_lvl = 0; m_ret = 1; end
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    check_all();
  endtask

  task automatic drv(input logic [3:0] req, input logic wfi, input logic irq,
                     input logic aon, input logic pin, input logic rdy);
    req_mode_i = req; wfi_i = wfi; wake_irq_i = irq; wake_aon_i = aon;
    wake_pin_i = pin; osc_rdy_i = rdy;
    step();
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired t=%0t", $time);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_ni = 1'b0;
    req_mode_i = 0; wfi_i = 0; wake_irq_i = 0; wake_aon_i = 0; wake_pin_i = 0;
    hfxt_req_i = 1; osc_rdy_i = 1;
    m_mode = 0; m_lvl = 0; m_ret = 0;
    e_sys = 1; e_hx = 0; e_cpu = 0; e_mc = 0; e_fast = 0; e_ulp = 0;
    e_sel = 0; e_tim = 0; e_drv = 3;
    repeat (2) @(negedge clk_i);
    check_all();  // R12 reset state
    rst_ni = 1'b1;

    // directed: STOP0 from each run level (R4), wake filtering (R6, R10)
    for (int l = 0; l < 3; l++) begin
      drv(4'(l), 1, 0, 0, 0, 1);
      drv(0, 0, 0, 0, 0, 1);
      drv(4, 1, 0, 0, 0, 1);        // enter STOP0
      drv(0, 0, 1, 0, 1, 1);        // irq and pin ignored in stop (R6)
      drv(0, 0, 0, 0, 0, 1);
      drv(0, 0, 0, 1, 0, 1);        // aon wakes back to level l (R10)
      drv(0, 0, 0, 0, 0, 1);
    end
    // sleep wakes on any irq (R6); unused request codes ignored (R12)
    drv(3, 1, 0, 0, 0, 1);
    drv(0, 0, 1, 0, 0, 1);
    drv(4'd13, 1, 0, 0, 0, 1);
    drv(0, 0, 0, 0, 0, 1);
    // shutdown, wrong wakes, pin wake (R7)
    drv(2, 1, 0, 0, 0, 1);
    drv(9, 1, 0, 0, 0, 1);
    drv(0, 0, 1, 1, 0, 1);
    drv(0, 0, 0, 0, 1, 0);          // wake with oscillator not ready (R11)
    drv(0, 0, 0, 0, 0, 0);
    drv(0, 0, 0, 0, 0, 1);
    drv(0, 1, 0, 0, 0, 1);          // clears retention flag
    // standby levels (R9)
    drv(8, 1, 0, 0, 0, 1);
    drv(0, 0, 0, 0, 0, 1);
    drv(0, 0, 0, 1, 0, 1);
    drv(7, 1, 0, 0, 0, 1);
    drv(0, 0, 0, 0, 0, 1);
    drv(0, 0, 0, 1, 0, 1);
    drv(0, 0, 0, 0, 0, 1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      hfxt_req_i = 1'($urandom % 2);
      drv(4'($urandom % 16), ($urandom % 5) == 0, ($urandom % 7) == 0,
          ($urandom % 9) == 0, ($urandom % 8) == 0, ($urandom % 6) != 0);
    end

    summary();
    $finish;
  end
endmodule